// File: doc/BRIEF.md
# Coarse Frequency Acquisition Loop with Dead-Band Filter

This block tunes the 8-bit coarse capacitor code of an oscillator before a phase loop takes over. It runs on the reference clock. Each reference cycle it receives a small count of oscillator events seen in that cycle, from an external prescaler. It adds these into a 12-bit measurement over a window of a fixed number of reference cycles. At the end of each window the total is compared with a 12-bit target word. A filter with a dead band nudges the coarse code by one step toward the target. It leaves the code alone when the frequency error is small, so it does not fight the phase loop.

The filter raises a lock flag after a run of consecutive windows whose error lies inside the dead band. The flag stays high until reset. Window length, dead-band half-width, lock run length and the reset code are parameters. The event input and the target word are plain signals sampled on every cycle. There is no handshake: the block never stalls, and there is no back-pressure to honour. The target word is read in the cycle that follows the end of a window, so it must be stable during that cycle.

Top module: `fll_coarse_tune`

## Requirements
- R1: During and right after reset, `coarse_code` equals RESET_CODE (default 128) and `locked` is 0.
- R2: When the target minus the window count exceeds DEAD_BAND (default 4), `coarse_code` rises by exactly 1. The change appears one cycle after the window's last cycle.
- R3: When the target minus the window count is below -DEAD_BAND, `coarse_code` falls by exactly 1 at that same point.
- R4: When the magnitude of the error is at most DEAD_BAND (both boundaries included), `coarse_code` holds.
- R5: `coarse_code` saturates. It never rises above 255 and never falls below 0, and it never wraps.
- R6: The window count saturates at 4095 instead of wrapping.
- R7: `locked` rises on the update of the LOCK_RUN-th consecutive in-band window (default 4). An out-of-band window restarts the run. Once high, `locked` stays high until reset.
- R8: A window lasts exactly WIN_CYCLES reference cycles (default 16). The count restarts from zero for each window.
- R9: `coarse_code` changes only in the cycle after a window ends, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_inc | input | INC_W (9) | Oscillator events counted in this reference cycle |
| fcw | input | 12 | Target count per window |
| coarse_code | output | 8 | Coarse capacitor bank code |
| locked | output | 1 | Sticky frequency-acquired flag |

## Verification
Two situations are hard to reach from the ports. The first is driving the coarse code to its rails. It takes over a hundred consecutive windows with a large error of one sign, so the bench holds that error for 130 and then 260 windows. The second is overflowing the 12-bit count, which only happens when the per-cycle increments stay near their maximum for a whole window. The bench drives all-ones increments against a target of 4095: a saturating count gives zero error, while a wrapping one would step the code. Dead-band edges are hit exactly by spreading a chosen total across the window. Seeded random windows placed near the target mix in-band and out-of-band results to break lock runs.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int CNT_W  = 12;
  localparam int CODE_W = 8;

  typedef logic [CNT_W-1:0]  count_t;
  typedef logic [CNT_W:0]    err_t;   // two's complement, one bit wider
  typedef logic [CODE_W-1:0] code_t;

  localparam count_t CNT_MAX  = '1;
  localparam code_t  CODE_MAX = '1;
endpackage

// File: rtl/fll_win_counter.sv
module fll_win_counter
  import fll_pkg::*;
#(
  parameter int WIN_CYCLES = 16,
  parameter int INC_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output count_t           meas,
  output logic             meas_vld
);
  localparam int TW    = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;

  logic [TW-1:0]    tick;
  count_t           acc;
  logic [SUM_W-1:0] sum;
  count_t           sum_sat;
  logic             last;

  always_comb begin
    sum     = SUM_W'(acc) + SUM_W'(inc);
    sum_sat = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
    last    = (tick == TW'(WIN_CYCLES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= '0;
      acc      <= '0;
      meas     <= '0;
      meas_vld <= 1'b0;
    end else begin
      tick     <= last ? '0 : tick + 1'b1;
      acc      <= last ? '0 : sum_sat;
      meas_vld <= last;
      if (last) meas <= sum_sat;
    end
  end
endmodule

// File: rtl/fll_deadband_filter.sv
module fll_deadband_filter
  import fll_pkg::*;
#(
  parameter int    DEAD_BAND  = 4,
  parameter code_t RESET_CODE = 8'd128
) (
  input  logic   clk,
  input  logic   rst_n,
  input  count_t meas,
  input  logic   meas_vld,
  input  count_t fcw,
  output code_t  code,
  output logic   in_band
);
  err_t err;
  err_t mag;
  logic neg;

  always_comb begin
    err     = err_t'({1'b0, fcw}) - err_t'({1'b0, meas});
    neg     = err[CNT_W];
    mag     = neg ? (~err + 1'b1) : err;
    in_band = (mag <= err_t'(DEAD_BAND));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= RESET_CODE;
    end else if (meas_vld && !in_band) begin
      if (!neg && code != CODE_MAX)    code <= code + 1'b1;
      else if (neg && code != '0)      code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/fll_lock_detect.sv
module fll_lock_detect #(
  parameter int LOCK_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_vld,
  input  logic in_band,
  output logic locked
);
  localparam int RW = $clog2(LOCK_RUN + 1);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (meas_vld) begin
      if (in_band) begin
        if (run != RW'(LOCK_RUN))     run <= run + 1'b1;
        if (run == RW'(LOCK_RUN - 1)) locked <= 1'b1;
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/fll_coarse_tune.sv
module fll_coarse_tune
  import fll_pkg::*;
#(
  parameter int    WIN_CYCLES = 16,
  parameter int    INC_W      = 9,
  parameter int    DEAD_BAND  = 4,
  parameter int    LOCK_RUN   = 4,
  parameter code_t RESET_CODE = 8'd128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] osc_inc,
  input  logic [11:0]      fcw,
  output logic [7:0]       coarse_code,
  output logic             locked
);
  count_t meas;
  logic   meas_vld;
  logic   in_band;
  code_t  code;

  fll_win_counter #(.WIN_CYCLES(WIN_CYCLES), .INC_W(INC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(osc_inc), .meas(meas), .meas_vld(meas_vld)
  );

  fll_deadband_filter #(.DEAD_BAND(DEAD_BAND), .RESET_CODE(RESET_CODE)) u_filt (
    .clk(clk), .rst_n(rst_n), .meas(meas), .meas_vld(meas_vld), .fcw(fcw),
    .code(code), .in_band(in_band)
  );

  fll_lock_detect #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .in_band(in_band),
    .locked(locked)
  );

  assign coarse_code = code;
endmodule

// File: rtl/fll_coarse_tune_chk.sv
module fll_coarse_tune_chk #(
  parameter int DEAD_BAND = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  code,
  input logic        locked,
  input logic [11:0] fcw,
  input logic [11:0] meas,
  input logic        meas_vld
);
  int err_i;
  logic band_chk;
  always_comb begin
    err_i    = int'(fcw) - int'(meas);
    band_chk = (err_i <= DEAD_BAND) && (err_i >= -DEAD_BAND);
  end

  // R9: no movement outside the update cycle
  assert_quiet_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> $stable(code));

  // R9: at most one step per update
  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> ((code == $past(code)) || (code == $past(code) + 8'd1) ||
                  (code == $past(code) - 8'd1)));

  // R4: error inside the band leaves the code alone
  assert_band_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && band_chk) |=> $stable(code));

  // R5: no wrap at the top rail
  assert_no_wrap_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && code == 8'hFF) |=> (code != 8'h00));

  // R5: no wrap at the bottom rail
  assert_no_wrap_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && code == 8'h00) |=> (code != 8'hFF));

  // R7: flag is sticky
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R8: window end marker is a single-cycle pulse
  assert_window_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> !meas_vld);
endmodule

bind fll_coarse_tune fll_coarse_tune_chk #(.DEAD_BAND(DEAD_BAND)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(coarse_code), .locked(locked), .fcw(fcw),
  .meas(meas), .meas_vld(meas_vld)
);

// File: tb/tb_fll_coarse_tune.sv
module tb_fll_coarse_tune;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 16;
  localparam int INC_W      = 9;
  localparam int BAND       = 4;
  localparam int LRUN       = 4;
  localparam int INC_MAX    = (1 << INC_W) - 1;
  localparam int TOT_MAX    = WIN * INC_MAX;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [INC_W-1:0] osc_inc = '0;
  logic [11:0]      fcw = '0;
  logic [7:0]       coarse_code;
  logic             locked;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int    exp_code = 128;
  int    exp_run  = 0;
  bit    exp_lock = 1'b0;
  bit    have_pend = 1'b0;
  string pend_tag = "";

  fll_coarse_tune #(.WIN_CYCLES(WIN), .INC_W(INC_W), .DEAD_BAND(BAND),
                    .LOCK_RUN(LRUN), .RESET_CODE(8'd128)) dut (
    .clk(clk), .rst_n(rst_n), .osc_inc(osc_inc), .fcw(fcw),
    .coarse_code(coarse_code), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int share(int total, int i);
    int q = total / WIN;
    int r = total % WIN;
    return q + ((i < r) ? 1 : 0);
  endfunction

  function automatic void model_window(int total, int f);
    int cnt = (total > 4095) ? 4095 : total;
    int e   = f - cnt;
    if (e > BAND) begin
      if (exp_code < 255) exp_code++;
      exp_run = 0;
    end else if (e < -BAND) begin
      if (exp_code > 0) exp_code--;
      exp_run = 0;
    end else begin
      if (exp_run < LRUN) exp_run++;
      if (exp_run == LRUN) exp_lock = 1'b1;
    end
  endfunction

  task automatic check_state(string tag);
    tests++;
    if (coarse_code !== 8'(exp_code)) begin
      fails++;
      $display("FAIL %s coarse_code got %0d expected %0d", tag, coarse_code, exp_code);
    end
    tests++;
    if (locked !== exp_lock) begin
      fails++;
      $display("FAIL %s locked got %0d expected %0d", tag, locked, exp_lock);
    end
  endtask

  task automatic run_window(int total, int f, string tag);
    int t = (total > TOT_MAX) ? TOT_MAX : ((total < 0) ? 0 : total);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (have_pend) check_state(pend_tag);
        fcw = 12'(f);
      end
      osc_inc = INC_W'(share(t, i));
    end
    model_window(t, f);
    pend_tag  = tag;
    have_pend = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd5));
    // R1: reset state
    repeat (3) @(negedge clk);
    check_state("R1");
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 / R3: single steps up and down
    run_window(900, 1000, "R2");
    run_window(1100, 1000, "R3");
    // R4: band edges
    run_window(996, 1000, "R4");
    run_window(995, 1000, "R4");
    run_window(1004, 1000, "R4");
    run_window(1005, 1000, "R4");
    // R7: run of in-band windows, then an out-of-band one
    for (int k = 0; k < LRUN; k++) run_window(1000 + k - 1, 1000, "R7");
    run_window(500, 1000, "R7");
    // R8: a large window followed by a small one must not carry over
    run_window(2000, 2000, "R8");
    run_window(100, 100, "R8");
    // R5: drive to the rails
    for (int k = 0; k < 130; k++) run_window(0, 3000, "R5");
    for (int k = 0; k < 260; k++) run_window(3000, 0, "R5");
    // R6: count overflow must saturate
    run_window(TOT_MAX, 4095, "R6");
    run_window(4200, 4095, "R6");
    run_window(TOT_MAX, 4080, "R6");
    // random windows near the target
    for (int k = 0; k < 150; k++) begin
      int f = int'($urandom_range(0, 4095));
      int t;
      if ($urandom_range(0, 3) == 0) t = int'($urandom_range(0, TOT_MAX));
      else t = f + int'($urandom_range(0, 20)) - 10;
      run_window(t, f, "R2/R3/R4/R7");
    end
    // flush the last pending result
    @(negedge clk);
    osc_inc = '0;
    @(negedge clk);
    check_state(pend_tag);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule